// File: doc/BRIEF.md
# Address Translation Unit with Page-Table Walker

This block turns virtual addresses from a single requester into physical addresses. It keeps recent translations in a small fully associative cache of translations (a TLB). When a lookup misses, it reads one entry of a linear, single-level page table from memory and sorts the result into one of these outcomes:

- a refill, which tells the requester to retry;
- a segmentation fault;
- a protection fault;
- a page fault.

A hit that the entry's permissions allow returns the physical address in the same transaction. A hit that they forbid returns a protection fault. Software sets the table base on `pt_base`. A `flush` pulse empties the cache.

The controller is a five-state machine:

- `S_IDLE` accepts a request (IDLE→LOOKUP on `req_valid`).
- `S_LOOKUP` searches the cache. LOOKUP→RESP on a hit. LOOKUP→FETCH on a miss.
- `S_FETCH` issues one memory read for the table entry (FETCH→WAIT).
- `S_WAIT` holds until the read data returns. It then classifies the entry and may insert it (WAIT→RESP).
- `S_RESP` presents the one-cycle response (RESP→IDLE).

Only one request is in flight at a time. `req_ready` is high only in `S_IDLE`.

Top module: `xlat_walker`

## Requirements
- R1: The page number is vaddr[31:12]. A permitted hit returns fault 0, retry 0 and paddr = {frame[19:0], vaddr[11:0]}, with no memory read.
- R2: Access codes are 0 = read, 1 = write, 2 = execute and 3 = none. Code 3 is allowed by no permission. A hit whose cached permission bits {r,w,x} forbid the access returns fault 2 (protection) with no memory read.
- R3: A miss issues exactly one memory read, at address pt_base + page_number*4.
- R4: The table entry is 25 bits: [24] valid, [23] present, [22:20] permissions {r,w,x}, [19:0] frame. If valid is 0, the response is fault 1 (segmentation), whatever the other bits hold.
- R5: A valid entry whose permissions forbid the access returns fault 2. This holds whether or not the present bit is set.
- R6: A valid, permitted, present entry is inserted into the cache. The response is retry 1 with fault 0. Repeating the same request then hits without a memory read.
- R7: A valid, permitted entry with present 0 returns fault 3 (page fault) and inserts nothing. A repeated request walks again.
- R8: A refill fills the lowest-numbered empty slot. When all 8 slots are full, it overwrites slots in rotating order starting from slot 0.
- R9: A one-cycle `flush` pulse invalidates every slot, so the next request for any page misses.
- R10: `req_ready` stays low from the accepting edge until the response has been presented. `resp_valid` and `mem_rd_valid` are single-cycle pulses, and only one memory read is outstanding at a time.
- R11: After reset, `req_ready` is 1, `resp_valid` is 0, `mem_rd_valid` is 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| pt_base | input | 32 | Byte address of the page table |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 exec, 3 none) |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_paddr | output | 32 | Physical address on a clean hit |
| resp_fault | output | 2 | 0 none, 1 segmentation, 2 protection, 3 page |
| resp_retry | output | 1 | Refill done, reissue the request |
| mem_rd_valid | output | 1 | Table-entry read strobe |
| mem_rd_addr | output | 32 | Table-entry byte address |
| mem_rd_resp_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 25 | Table entry read from memory |

## Verification
On every cycle, the assertions check the following:
- the single-pulse and hold-off rules of the handshake;
- the table-entry address formed for each read;
- that a retry never carries a fault;
- that a clean hit keeps the page offset;
- that an invalid entry always produces a segmentation fault;
- that the cache holds no duplicate matches and is empty after a flush.

Only the bench's scenarios can show the behaviours that span several requests. These are:
- the priority order of the checks, swept over every combination of valid, present, permission and access type;
- the fact that a refill really makes the next request hit;
- that a page fault leaves the cache untouched;
- the exact slot the rotating replacement overwrites.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_SEG  = 2'd1,
        FLT_PROT = 2'd2,
        FLT_PAGE = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } access_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_FETCH,
        S_WAIT,
        S_RESP
    } walk_state_e;

    // Permission field is {read, write, exec}
    function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] acc);
        logic ok;
        unique case (acc)
            ACC_READ:  ok = perm[2];
            ACC_WRITE: ok = perm[1];
            ACC_EXEC:  ok = perm[0];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PFN_W     = 20,
    parameter int MA_W      = 32,
    parameter int PTE_BYTES = 4,
    localparam int VPN_W    = VA_W - OFF_W,
    localparam int PA_W     = PFN_W + OFF_W
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [MA_W-1:0]  pt_base,
    input  logic [PFN_W-1:0] pfn,
    output logic [VPN_W-1:0] vpn,
    output logic [MA_W-1:0]  pte_addr,
    output logic [PA_W-1:0]  paddr
);
    logic [OFF_W-1:0] offset;

    always_comb begin
        vpn      = vaddr[VA_W-1:OFF_W];
        offset   = vaddr[OFF_W-1:0];
        pte_addr = pt_base + (MA_W'(vpn) * MA_W'(PTE_BYTES));
        paddr    = {pfn, offset};
    end
endmodule

// File: rtl/xlat_pte_classify.sv
module xlat_pte_classify
    import xlat_walker_pkg::*;
#(
    parameter int PFN_W = 20,
    localparam int PTE_W    = PFN_W + 5,
    localparam int V_BIT    = PTE_W - 1,
    localparam int P_BIT    = PTE_W - 2,
    localparam int PERM_HI  = PTE_W - 3,
    localparam int PERM_LO  = PTE_W - 5
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       acc,
    output fault_e           fault,
    output logic             do_insert,
    output logic [2:0]       perm,
    output logic [PFN_W-1:0] pfn
);
    always_comb begin
        perm      = pte[PERM_HI:PERM_LO];
        pfn       = pte[PFN_W-1:0];
        do_insert = 1'b0;
        // Fixed order: valid, then permission, then presence
        if (!pte[V_BIT]) begin
            fault = FLT_SEG;
        end else if (!perm_allows(perm, acc)) begin
            fault = FLT_PROT;
        end else if (!pte[P_BIT]) begin
            fault = FLT_PAGE;
        end else begin
            fault     = FLT_NONE;
            do_insert = 1'b1;
        end
    end
endmodule

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic [2:0]       lk_perm,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PFN_W-1:0] ins_pfn,
    input  logic [2:0]       ins_perm
);
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    logic [2:0]         perm_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   free_idx;
    logic               any_free;
    logic [IDX_W-1:0]   slot;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
        end
    endgenerate

    always_comb begin
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_pfn  = lk_pfn | pfn_q[i];
                lk_perm = lk_perm | perm_q[i];
            end
        end
        lk_hit = |match;
    end

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        slot = any_free ? free_idx : rr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (ins_en) begin
            valid_q[slot] <= 1'b1;
            if (!any_free) begin
                rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en && !flush) begin
            vpn_q[slot]  <= ins_vpn;
            pfn_q[slot]  <= ins_pfn;
            perm_q[slot] <= ins_perm;
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R9
    AST_ROTATE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && any_free && !flush) |=> $stable(rr_q)); // R8
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_walker_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PFN_W     = 20,
    parameter int MA_W      = 32,
    parameter int PTE_BYTES = 4,
    parameter int ENTRIES   = 8,
    localparam int VPN_W    = VA_W - OFF_W,
    localparam int PA_W     = PFN_W + OFF_W,
    localparam int PTE_W    = PFN_W + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [MA_W-1:0]  pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [1:0]       resp_fault,
    output logic             resp_retry,
    output logic             mem_rd_valid,
    output logic [MA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_resp_valid,
    input  logic [PTE_W-1:0] mem_rd_data
);
    walk_state_e state_q, state_d;

    logic [VA_W-1:0]  vaddr_q;
    logic [1:0]       acc_q;
    logic [MA_W-1:0]  maddr_q;
    logic [PA_W-1:0]  paddr_q;
    fault_e           fault_q;
    logic             retry_q;

    logic [VPN_W-1:0] vpn;
    logic [MA_W-1:0]  pte_addr;
    logic [PA_W-1:0]  hit_paddr;
    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic [2:0]       lk_perm;
    fault_e           cls_fault;
    logic             cls_insert;
    logic [2:0]       cls_perm;
    logic [PFN_W-1:0] cls_pfn;
    logic             ins_en;

    xlat_addr_gen #(
        .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .MA_W(MA_W), .PTE_BYTES(PTE_BYTES)
    ) u_addr (
        .vaddr(vaddr_q), .pt_base(pt_base), .pfn(lk_pfn),
        .vpn(vpn), .pte_addr(pte_addr), .paddr(hit_paddr)
    );

    xlat_tlb_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
        .ins_en(ins_en), .ins_vpn(vpn), .ins_pfn(cls_pfn), .ins_perm(cls_perm)
    );

    xlat_pte_classify #(
        .PFN_W(PFN_W)
    ) u_cls (
        .pte(mem_rd_data), .acc(acc_q),
        .fault(cls_fault), .do_insert(cls_insert), .perm(cls_perm), .pfn(cls_pfn)
    );

    assign ins_en = (state_q == S_WAIT) && mem_rd_resp_valid && cls_insert;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_LOOKUP;
            S_LOOKUP: state_d = lk_hit ? S_RESP : S_FETCH;
            S_FETCH:  state_d = S_WAIT;
            S_WAIT:   if (mem_rd_resp_valid) state_d = S_RESP;
            S_RESP:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            acc_q   <= '0;
            maddr_q <= '0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
            retry_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        acc_q   <= req_acc;
                    end
                end
                S_LOOKUP: begin
                    retry_q <= 1'b0;
                    if (lk_hit) begin
                        if (perm_allows(lk_perm, acc_q)) begin
                            fault_q <= FLT_NONE;
                            paddr_q <= hit_paddr;
                        end else begin
                            fault_q <= FLT_PROT;
                            paddr_q <= '0;
                        end
                    end else begin
                        maddr_q <= pte_addr;
                    end
                end
                S_WAIT: begin
                    if (mem_rd_resp_valid) begin
                        fault_q <= cls_fault;
                        retry_q <= cls_insert;
                        paddr_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state_q == S_IDLE);
        mem_rd_valid = (state_q == S_FETCH);
        mem_rd_addr  = maddr_q;
        resp_valid   = (state_q == S_RESP);
        resp_paddr   = paddr_q;
        resp_fault   = fault_q;
        resp_retry   = retry_q;
    end

    AST_ONE_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid); // R10
    AST_HOLD_OFF_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !req_ready); // R10
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R10
    AST_PTE_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr == pt_base + (MA_W'(vaddr_q >> OFF_W) << $clog2(PTE_BYTES)))); // R3
    AST_RETRY_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_retry) |-> (resp_fault == FLT_NONE)); // R6
    AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_retry && resp_fault == FLT_NONE) |-> (resp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0])); // R1
    AST_INVALID_IS_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && mem_rd_resp_valid && !mem_rd_data[PTE_W-1]) |=> (resp_valid && resp_fault == FLT_SEG)); // R4
endmodule

// File: tb/tb_xlat_walker.sv
module tb_xlat_walker;
    localparam logic [31:0] PT_BASE = 32'h0008_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic [1:0]  resp_fault;
    logic        resp_retry;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_resp_valid = 1'b0;
    logic [24:0] mem_rd_data = '0;

    logic [24:0] pte_mem [64];
    int n_chk = 0;
    int n_bad = 0;
    int mem_reads = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xlat_walker dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(PT_BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .resp_retry(resp_retry), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_resp_valid(mem_rd_resp_valid), .mem_rd_data(mem_rd_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Page-table memory model: 3-cycle read latency
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_rd_valid) begin
                logic [31:0] a;
                logic [31:0] idx;
                a = mem_rd_addr;
                mem_reads++;
                idx = (a - PT_BASE) >> 2;
                check((a >= PT_BASE) && (idx < 64) && (a[1:0] == 2'b00), "R3", "table address", a, PT_BASE);
                repeat (3) @(negedge clk);
                mem_rd_data = (idx < 64) ? pte_mem[idx[5:0]] : '0;
                mem_rd_resp_valid = 1'b1;
                @(negedge clk);
                mem_rd_resp_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    function automatic bit allows(input logic [2:0] perm, input logic [1:0] acc);
        case (acc)
            2'd0: return perm[2];
            2'd1: return perm[1];
            2'd2: return perm[0];
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, input logic [1:0] acc,
                         output logic [1:0] flt, output logic rt,
                         output logic [31:0] pa, output int reads);
        int start;
        int t;
        bit early;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        start = mem_reads;
        req_vaddr = va;
        req_acc = acc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        early = 0;
        while (!resp_valid && t < 100) begin
            if (req_ready) early = 1;
            @(negedge clk);
            t++;
        end
        check(!early && t < 100, "R10", "ready held low until response", {63'd0, early}, 64'd0);
        flt = resp_fault;
        rt = resp_retry;
        pa = resp_paddr;
        reads = mem_reads - start;
    endtask

    logic [1:0]  f;
    logic        r;
    logic [31:0] p;
    int          n;

    initial begin
        for (int i = 0; i < 64; i++) pte_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
        check(resp_valid == 1'b0, "R11", "resp_valid after reset", resp_valid, 0);
        check(mem_rd_valid == 1'b0, "R11", "mem_rd_valid after reset", mem_rd_valid, 0);

        // Sweep valid x present x perm x access
        for (int cfg = 0; cfg < 32; cfg++) begin
            for (int acc = 0; acc < 4; acc++) begin
                logic v, pr;
                logic [2:0] pm;
                logic [19:0] frame;
                logic [19:0] vpn;
                logic [11:0] off;
                logic [31:0] va;
                logic [1:0] exp_f;
                v = cfg[4];
                pr = cfg[3];
                pm = cfg[2:0];
                vpn = 20'(cfg + 8);
                frame = 20'h0A000 + 20'(cfg * 17 + acc);
                off = 12'((cfg * 37 + acc * 101) & 12'hFFF);
                va = {vpn, off};
                pte_mem[vpn[5:0]] = {v, pr, pm, frame};
                if (!v) exp_f = 2'd1;
                else if (!allows(pm, 2'(acc))) exp_f = 2'd2;
                else if (!pr) exp_f = 2'd3;
                else exp_f = 2'd0;
                do_flush();
                xlate(va, 2'(acc), f, r, p, n);
                check(n == 1, "R3", "reads on miss", 64'(n), 1);
                if (exp_f == 2'd1) check(f == 2'd1 && !r, "R4", "invalid entry", {f, r}, {2'd1, 1'b0});
                else if (exp_f == 2'd2) check(f == 2'd2 && !r, "R5", "walk permission", {f, r}, {2'd2, 1'b0});
                else if (exp_f == 2'd3) check(f == 2'd3 && !r, "R7", "not present", {f, r}, {2'd3, 1'b0});
                else check(f == 2'd0 && r, "R6", "refill retry", {f, r}, {2'd0, 1'b1});
                if (exp_f == 2'd0) begin
                    xlate(va, 2'(acc), f, r, p, n);
                    check(n == 0 && !r && f == 2'd0, "R6", "retry hits", 64'(n), 0);
                    check(p == {frame, off}, "R1", "hit paddr", p, {frame, off});
                    for (int a2 = 0; a2 < 4; a2++) begin
                        xlate(va, 2'(a2), f, r, p, n);
                        if (allows(pm, 2'(a2)))
                            check(f == 2'd0 && n == 0 && p == {frame, off}, "R1", "hit other access", {f, p}, {2'd0, frame, off});
                        else
                            check(f == 2'd2 && n == 0 && !r, "R2", "hit protection", {f, 30'(n)}, {2'd2, 30'd0});
                    end
                    do_flush();
                    xlate(va, 2'(acc), f, r, p, n);
                    check(n == 1 && r, "R9", "miss after flush", 64'(n), 1);
                end else if (exp_f == 2'd3) begin
                    xlate(va, 2'(acc), f, r, p, n);
                    check(n == 1 && f == 2'd3, "R7", "page fault not cached", 64'(n), 1);
                end
            end
        end

        // Replacement order
        for (int k = 40; k < 50; k++) pte_mem[k] = {1'b1, 1'b1, 3'b111, 20'(k * 3)};
        do_flush();
        for (int k = 40; k < 50; k++) begin
            xlate({20'(k), 12'h010}, 2'd0, f, r, p, n);
            check(n == 1 && r, "R8", "fill refill", 64'(n), 1);
        end
        for (int k = 42; k < 50; k++) begin
            xlate({20'(k), 12'h020}, 2'd0, f, r, p, n);
            check(n == 0 && p == {20'(k * 3), 12'h020}, "R8", "resident after rotation", {32'(n), p}, {32'd0, 20'(k * 3), 12'h020});
        end
        xlate({20'd40, 12'h0}, 2'd0, f, r, p, n);
        check(n == 1, "R8", "slot 0 overwritten", 64'(n), 1);
        xlate({20'd41, 12'h0}, 2'd0, f, r, p, n);
        check(n == 1, "R8", "slot 1 overwritten", 64'(n), 1);
        xlate({20'd42, 12'h0}, 2'd0, f, r, p, n);
        check(n == 1, "R8", "slot 2 replaced by refill of page 40", 64'(n), 1);
        xlate({20'd43, 12'h0}, 2'd0, f, r, p, n);
        check(n == 1, "R8", "slot 3 replaced by refill of page 41", 64'(n), 1);

        done = 1;
        summary();
        $finish;
    end
endmodule